// File: doc/BRIEF.md
# Heartbeat Watchdog Timer with Float and Supply Gating

This block supervises a processor heartbeat. Software is expected to flip the level of the heartbeat input at regular intervals. Either kind of level change, rising or falling, restarts an internal count. If no level change arrives within a programmable number of clock cycles, the active-low watchdog output drops. It stays low until the next level change or until something clears the timer.

The timer is held at zero and cannot expire in two cases:

- while the system reset is asserted;
- while an external float detector reports that nobody is driving the heartbeat pin.

When neither case applies, counting resumes on the very next clock. In effect, leaving the pin floating switches the watchdog off.

Independently of the timer, a false supply-good flag forces the output low in the same cycle. When supply-good returns, the output comes back high at once, with no hold-off, provided the timer has not expired.

The heartbeat input arrives already synchronized. The clock must be fast enough that a 50 ns pulse spans at least one sampling edge. At the bench clock, that pulse is about six cycles long.

Top module: `wdt_heartbeat_monitor`

## Requirements
- R1: With `TIMEOUT_CYCLES` = T, if T rising clock edges pass after the last clearing edge with no heartbeat level change and no hold, `wdo_no` goes low after the T-th edge; it is high after edges 0..T-1.
- R2: A rising and a falling change of `hb_i` both restart the count from zero; the change is seen at the first clock edge that samples the new level.
- R3: Once expired, `wdo_no` stays low for any number of further cycles until a heartbeat level change, which returns it high after the edge that samples the change.
- R4: While `sys_rst_i` is 1, the count is held at zero and an expired state is cleared, so `wdo_no` is high after the first edge that samples `sys_rst_i` = 1, for as long as supply is good.
- R5: While `hb_driven_i` is 0 (pin floating), the count is held at zero and an expired state is cleared, so the watchdog never fires however long the pin floats.
- R6: Counting starts on the first clock edge at which `sys_rst_i` is 0 and `hb_driven_i` is 1, with the timing of R1.
- R7: When `supply_ok_i` is 0, `wdo_no` is 0 combinationally in the same cycle, whatever the timer state.
- R8: When `supply_ok_i` returns to 1, `wdo_no` follows the timer state immediately. Supply-good does not stop or clear the count, so expiry happens at the same edge as it would without the supply dip.
- R9: A heartbeat pulse as short as one clock period is detected as two level changes, and the count restarts from the second one.
- R10: While `rst_ni` is low, the timer is cleared asynchronously and `wdo_no` equals `supply_ok_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| hb_i | input | 1 | Synchronized heartbeat level |
| hb_driven_i | input | 1 | 1 when the heartbeat pin is actively driven, 0 when it floats |
| sys_rst_i | input | 1 | 1 while the system reset is asserted |
| supply_ok_i | input | 1 | 1 when the supervised supply is good |
| wdo_no | output | 1 | Active-low watchdog flag |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 8. With that value, the cycle at which the output drops can be checked at every position of the window for every heartbeat gap from 1 to T+2. The same small value keeps long holds, float periods and supply dips within a few dozen cycles. Expiry is an exact arithmetic rule: the output is low exactly when the number of edges since the last clear is at least 8. The bench checks every cycle against that rule.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_HELD    = 2'd0,
    WD_RUN     = 2'd1,
    WD_EXPIRED = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdt_edge_det.sv
module wdt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic edge_o
);
  logic hb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hb_q <= 1'b0;
    else         hb_q <= hb_i;
  end

  // either polarity counts as activity
  assign edge_o = hb_i ^ hb_q;

  a_r2_level_tracked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hb_q == $past(hb_i)));
endmodule

// File: rtl/wdt_timeout_cnt.sv
module wdt_timeout_cnt
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW   = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int unsigned LAST = TIMEOUT_CYCLES - 1;

  logic [CW-1:0] cnt_q;
  wd_state_e     state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= WD_HELD;
    end else if (hold_i) begin
      cnt_q   <= '0;
      state_q <= WD_HELD;
    end else if (restart_i) begin
      cnt_q   <= '0;
      state_q <= WD_RUN;
    end else if (state_q != WD_EXPIRED) begin
      if (cnt_q == CW'(LAST)) begin
        state_q <= WD_EXPIRED;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        state_q <= WD_RUN;
      end
    end
  end

  assign expired_o = (state_q == WD_EXPIRED);

  initial begin
    a_r1_timeout_min: assert (TIMEOUT_CYCLES >= 2);
  end

  a_r1_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LAST));
  a_r1_expire_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(LAST) && !hold_i && !restart_i) |=> expired_o);
  a_r2_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !hold_i) |=> (cnt_q == '0 && state_q == WD_RUN));
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !hold_i && !restart_i) |=> expired_o);
  a_r4_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0 && !expired_o));
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !restart_i && !expired_o && cnt_q != CW'(LAST))
      |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic expired_i,
  output logic wdo_no
);
  // supply gating is combinational: no hold-off on recovery
  assign wdo_no = supply_ok_i & ~expired_i;

  a_r7_supply_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !wdo_no);
  a_r8_recover_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && !expired_i) |-> wdo_no);
endmodule

// File: rtl/wdt_heartbeat_monitor.sv
module wdt_heartbeat_monitor #(
  parameter int unsigned TIMEOUT_CYCLES = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  input  logic hb_driven_i,
  input  logic sys_rst_i,
  input  logic supply_ok_i,
  output logic wdo_no
);
  logic hb_edge;
  logic hold;
  logic expired;

  assign hold = sys_rst_i | ~hb_driven_i;

  wdt_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hb_i   (hb_i),
    .edge_o (hb_edge)
  );

  wdt_timeout_cnt #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .restart_i (hb_edge),
    .expired_o (expired)
  );

  wdt_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .expired_i   (expired),
    .wdo_no      (wdo_no)
  );

  a_r5_float_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hb_driven_i && supply_ok_i) |=> (wdo_no || !supply_ok_i));
  a_r4_sysrst_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && supply_ok_i) |=> (wdo_no || !supply_ok_i));
endmodule

// File: tb/sim_wdt_heartbeat_monitor.sv
`timescale 1ns/1ps
module sim_wdt_heartbeat_monitor;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hb = 1'b0;
  logic hb_driven = 1'b1;
  logic sys_rst = 1'b1;
  logic supply_ok = 1'b1;
  logic wdo_n;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wdt_heartbeat_monitor #(.TIMEOUT_CYCLES(T)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .hb_i        (hb),
    .hb_driven_i (hb_driven),
    .sys_rst_i   (sys_rst),
    .supply_ok_i (supply_ok),
    .wdo_no      (wdo_n)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    n_run++;
    if (wdo_n !== exp) begin
      n_fail++;
      $display("FAIL %s: wdo_no=%b expected %b at %0t", tag, wdo_n, exp, $time);
    end
  endtask

  // n edges after the last clear: low iff n >= T
  task automatic window(input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      tick();
      chk((i >= T) ? 1'b0 : 1'b1, tag);
    end
  endtask

  task automatic toggle(input string tag);
    hb = ~hb;
    tick();
    chk(1'b1, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R10: async reset state
    #1;
    chk(1'b1, "R10 reset supply ok");
    supply_ok = 1'b0; #1;
    chk(1'b0, "R10 reset supply low");
    supply_ok = 1'b1;
    tick(); tick();
    rst_ni = 1'b1;
    tick(); tick();
    chk(1'b1, "R4 held under sys reset");

    // R6 / R1: count begins at release
    sys_rst = 1'b0;
    chk(1'b1, "R6 release");
    window(T + 3, "R6 R1 first window");

    // R3: sticky
    for (int i = 0; i < 2 * T; i++) begin
      tick();
      chk(1'b0, "R3 sticky low");
    end
    toggle("R3 edge recovers");

    // R2 / R1: gap sweep with alternating polarity
    for (int g = 1; g <= T + 2; g++) begin
      window(g, "R1 R2 gap sweep");
      toggle("R2 restart");
    end

    // R9: one-cycle pulse
    window(T, "R9 expire before pulse");
    hb = ~hb; tick();
    chk(1'b1, "R9 pulse first edge");
    hb = ~hb; tick();
    chk(1'b1, "R9 pulse second edge");
    window(T + 1, "R9 window after pulse");

    // R5: floating pin clears and disables
    hb_driven = 1'b0; tick();
    chk(1'b1, "R5 float clears expiry");
    for (int i = 0; i < 3 * T; i++) begin
      tick();
      chk(1'b1, "R5 float never fires");
    end
    hb_driven = 1'b1;
    chk(1'b1, "R6 float release");
    window(T + 1, "R6 count after float");

    // R4: system reset mid-count
    toggle("R4 prep");
    window(T - 2, "R4 pre-count");
    sys_rst = 1'b1; tick();
    chk(1'b1, "R4 sys reset clears");
    for (int i = 0; i < 2 * T; i++) begin
      tick();
      chk(1'b1, "R4 held");
    end
    hb = ~hb; tick(); tick();
    chk(1'b1, "R4 edge during hold");
    sys_rst = 1'b0;
    window(T + 1, "R4 count after release");

    // R7 / R8: supply dip does not disturb the count
    toggle("R7 prep");
    tick(); tick();
    supply_ok = 1'b0; #1;
    chk(1'b0, "R7 immediate low");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(1'b0, "R7 held low");
    end
    supply_ok = 1'b1; #1;
    chk(1'b1, "R8 immediate recovery");
    tick(); tick();
    chk(1'b1, "R8 n=7 still high");
    tick();
    chk(1'b0, "R8 expiry unmoved by dip");
    supply_ok = 1'b0; #1;
    chk(1'b0, "R7 low while expired");
    supply_ok = 1'b1; #1;
    chk(1'b0, "R8 expired stays low");

    // R10: async reset clears expired state
    rst_ni = 1'b0; #1;
    chk(1'b1, "R10 async clear");
    tick();
    rst_ni = 1'b1;

    summary();
    $finish;
  end
endmodule